// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one programmable output cell. It takes a sum-of-products data term, six control terms and three clock sources: a pin clock for source 0, and for source 1 either a second pin clock or a clock produced by logic. It also takes an active-low global tri-state pin and the level seen at its own pad. Per-cell configuration bits choose several things. The storage element acts as a D or T flip-flop, or is bypassed so the data term goes straight out. The configuration also picks the clock source and its active edge, which control term presets or resets the register and how, and what enables the output buffer.

The cell runs in one system clock domain. The clock sources are sampled on each rising edge of `clk`. A change of the selected source between two samples, in the chosen direction, is an active edge, and the register takes its new value on that same `clk` edge. The preset and reset work at once: they override the cell value in the same cycle and keep the register loaded while they stay high. There are two feedback outputs. One carries the cell value before the output buffer. The other carries what the pad shows: the driven value when the buffer is enabled, or the outside level when it is not.

Top module: `cfg_macrocell`

## Requirements
- R1: A synchronous reset clears the register to 0, and the clock-edge history is cleared with it.
- R2: In D mode (`cfg_t_mode`=0) the register loads `sop_in` on each active edge of the selected clock source.
- R3: In T mode (`cfg_t_mode`=1) the register inverts on an active edge when `sop_in` is 1 and holds when `sop_in` is 0.
- R4: With `cfg_clk_fall`=0 the active edge is a 0-to-1 change of the selected source between consecutive `clk` samples, and with `cfg_clk_fall`=1 it is a 1-to-0 change. Without an active edge the register holds.
- R5: `cfg_clk_sel`=0 selects `clk0_pin`. `cfg_clk_sel`=1 selects `clk1_pin` when `cfg_clk1_eqn`=0 and `clk1_eqn` when `cfg_clk1_eqn`=1.
- R6: `cfg_init_src` 0 disables init. Code 1 makes `ct[0]` the init term and code 2 makes `ct[1]` the init term. While that term is 1, the cell value equals `cfg_init_preset` in the same cycle, and the register holds that value afterwards.
- R7: `cfg_init_src`=3 makes `ct[0]` a reset and `ct[1]` a preset. When both are 1, the reset wins and the value is 0.
- R8: With `cfg_bypass`=1, `fb_cell` and `pin_out` equal `sop_in` in the same cycle.
- R9: `cfg_oe_sel` codes 0 to 3 take the enable from `ct[2]` to `ct[5]` in that order. Code 4 enables the buffer always, and codes 5 to 7 disable it.
- R10: When `cfg_gts_en`=1 and `gts_n`=0, `pin_oe` is 0 whatever the enable selection.
- R11: `fb_pin` equals `pin_out` when `pin_oe` is 1 and equals `pin_in` otherwise. `pin_out` always equals `fb_cell`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every source |
| rst | input | 1 | Synchronous active-high reset |
| sop_in | input | 1 | Sum-of-products data term |
| ct | input | 6 | Control terms |
| clk0_pin | input | 1 | Clock source 0 from a pin |
| clk1_pin | input | 1 | Clock source 1 from a pin |
| clk1_eqn | input | 1 | Clock source 1 from logic |
| gts_n | input | 1 | Global tri-state, active low |
| pin_in | input | 1 | Outside level at the pad |
| cfg_t_mode | input | 1 | 1 selects T mode, 0 selects D mode |
| cfg_bypass | input | 1 | 1 routes sop_in straight to the output |
| cfg_clk_sel | input | 1 | Clock source select |
| cfg_clk1_eqn | input | 1 | Source 1 taken from logic |
| cfg_clk_fall | input | 1 | 1 selects the falling edge |
| cfg_init_src | input | 2 | Init source code |
| cfg_init_preset | input | 1 | Init value for codes 1 and 2 |
| cfg_oe_sel | input | 3 | Output enable select |
| cfg_gts_en | input | 1 | Lets gts_n act on this cell |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Output buffer enable |
| fb_cell | output | 1 | Feedback taken before the buffer |
| fb_pin | output | 1 | Feedback taken from the pad |

## Verification
A register update caused by a clock-source edge appears on `fb_cell` just after the `clk` rising edge that samples the new source level, because one register lies on that path. Init, bypass, enable selection, tri-state and pad feedback settle in the same cycle as their inputs. The bench drives every input on the falling edge of `clk` and steps its own model of the register on the rising edge. It then compares all four outputs at the next falling edge, so each result is read after it has settled and before the inputs move again.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CT_COUNT  = 6;
    localparam int OE_BASE   = 2;
    localparam int OE_COUNT  = 4;
    localparam int OE_SEL_W  = 3;
    localparam int INIT_W    = 2;

    typedef enum logic [INIT_W-1:0] {
        INIT_OFF   = 2'd0,
        INIT_TERM0 = 2'd1,
        INIT_TERM1 = 2'd2,
        INIT_SPLIT = 2'd3
    } init_src_e;

    typedef struct packed {
        logic      t_mode;
        logic      bypass;
        logic      clk_sel;
        logic      clk1_eqn;
        logic      clk_fall;
        init_src_e init_src;
        logic      init_preset;
        logic [OE_SEL_W-1:0] oe_sel;
        logic      gts_en;
    } mc_cfg_t;

    typedef struct packed {
        logic act;
        logic val;
    } init_req_t;

    function automatic logic next_state(input logic t_mode, input logic q, input logic d);
        return t_mode ? (q ^ d) : d;
    endfunction

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel (
    input  logic clk,
    input  logic rst,
    input  logic src0,
    input  logic src1_pin,
    input  logic src1_eqn,
    input  logic sel,
    input  logic use_eqn,
    input  logic fall,
    output logic fire
);
    logic lvl;
    logic lvl_q;

    always_comb begin
        if (sel) lvl = use_eqn ? src1_eqn : src1_pin;
        else     lvl = src0;
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign fire = fall ? (lvl_q & ~lvl) : (lvl & ~lvl_q);
endmodule

// File: rtl/mc_init_dec.sv
module mc_init_dec
    import mc_pkg::*;
(
    input  logic [1:0]  term,
    input  init_src_e   src,
    input  logic        preset,
    output init_req_t   req
);
    always_comb begin
        req = '0;
        unique case (src)
            INIT_OFF:   req = '0;
            INIT_TERM0: begin req.act = term[0]; req.val = preset; end
            INIT_TERM1: begin req.act = term[1]; req.val = preset; end
            INIT_SPLIT: begin
                req.act = term[0] | term[1];
                req.val = ~term[0];
            end
            default:    req = '0;
        endcase
    end
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  logic      t_mode,
    input  logic      d_in,
    input  init_req_t init,
    output logic      q_eff
);
    logic q_reg;

    always_ff @(posedge clk) begin
        if (rst)           q_reg <= 1'b0;
        else if (init.act) q_reg <= init.val;
        else if (fire)     q_reg <= next_state(t_mode, q_reg, d_in);
    end

    assign q_eff = init.act ? init.val : q_reg;
endmodule

// File: rtl/mc_oe_sel.sv
module mc_oe_sel #(
    parameter int COUNT = 4,
    parameter int SEL_W = 3
) (
    input  logic [COUNT-1:0] oe_terms,
    input  logic [SEL_W-1:0] sel,
    input  logic             gts_en,
    input  logic             gts_n,
    output logic             oe
);
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic base;

    always_comb begin
        if (int'(sel) < COUNT)       base = oe_terms[sel[IDX_W-1:0]];
        else if (int'(sel) == COUNT) base = 1'b1;
        else                         base = 1'b0;
    end

    assign oe = base & ~(gts_en & ~gts_n);
endmodule

// File: rtl/cfg_macrocell.sv
module cfg_macrocell
    import mc_pkg::*;
#(
    parameter int CT_W   = CT_COUNT,
    parameter int OSEL_W = OE_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sop_in,
    input  logic [CT_W-1:0]   ct,
    input  logic              clk0_pin,
    input  logic              clk1_pin,
    input  logic              clk1_eqn,
    input  logic              gts_n,
    input  logic              pin_in,
    input  logic              cfg_t_mode,
    input  logic              cfg_bypass,
    input  logic              cfg_clk_sel,
    input  logic              cfg_clk1_eqn,
    input  logic              cfg_clk_fall,
    input  logic [1:0]        cfg_init_src,
    input  logic              cfg_init_preset,
    input  logic [OSEL_W-1:0] cfg_oe_sel,
    input  logic              cfg_gts_en,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_cell,
    output logic              fb_pin
);
    mc_cfg_t   cfg;
    init_req_t init_req;
    logic      fire;
    logic      q_eff;
    logic      cell_val;

    always_comb begin
        cfg.t_mode      = cfg_t_mode;
        cfg.bypass      = cfg_bypass;
        cfg.clk_sel     = cfg_clk_sel;
        cfg.clk1_eqn    = cfg_clk1_eqn;
        cfg.clk_fall    = cfg_clk_fall;
        cfg.init_src    = init_src_e'(cfg_init_src);
        cfg.init_preset = cfg_init_preset;
        cfg.oe_sel      = cfg_oe_sel;
        cfg.gts_en      = cfg_gts_en;
    end

    mc_clk_sel u_clk (
        .clk      (clk),
        .rst      (rst),
        .src0     (clk0_pin),
        .src1_pin (clk1_pin),
        .src1_eqn (clk1_eqn),
        .sel      (cfg.clk_sel),
        .use_eqn  (cfg.clk1_eqn),
        .fall     (cfg.clk_fall),
        .fire     (fire)
    );

    mc_init_dec u_init (
        .term   (ct[1:0]),
        .src    (cfg.init_src),
        .preset (cfg.init_preset),
        .req    (init_req)
    );

    mc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .t_mode (cfg.t_mode),
        .d_in   (sop_in),
        .init   (init_req),
        .q_eff  (q_eff)
    );

    mc_oe_sel #(.COUNT(OE_COUNT), .SEL_W(OSEL_W)) u_oe (
        .oe_terms (ct[OE_BASE+OE_COUNT-1:OE_BASE]),
        .sel      (cfg.oe_sel),
        .gts_en   (cfg.gts_en),
        .gts_n    (gts_n),
        .oe       (pin_oe)
    );

    assign cell_val = cfg.bypass ? sop_in : q_eff;
    assign fb_cell  = cell_val;
    assign pin_out  = cell_val;
    assign fb_pin   = pin_oe ? cell_val : pin_in;
endmodule

// File: rtl/mc_chk.sv
module mc_chk (
    input logic       clk,
    input logic       rst,
    input logic       sop_in,
    input logic [5:0] ct,
    input logic       gts_n,
    input logic       pin_in,
    input logic       cfg_bypass,
    input logic [1:0] cfg_init_src,
    input logic       cfg_init_preset,
    input logic [2:0] cfg_oe_sel,
    input logic       cfg_gts_en,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_cell,
    input logic       fb_pin
);
    // R10
    gts_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_gts_en && !gts_n) |-> !pin_oe);

    // R11
    pad_fb_driven_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> (fb_pin == pin_out));

    // R11
    pad_fb_input_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> (fb_pin == pin_in));

    // R9
    oe_always_on_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 3'd4 && !(cfg_gts_en && !gts_n)) |-> pin_oe);

    // R9
    oe_off_codes_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel > 3'd4) |-> !pin_oe);

    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |-> (fb_cell == sop_in));

    // R6
    init_term0_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_init_src == 2'd1 && ct[0] && !cfg_bypass) |-> (fb_cell == cfg_init_preset));

    // R7
    split_reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_init_src == 2'd3 && ct[0] && !cfg_bypass) |-> !fb_cell);
endmodule

bind cfg_macrocell mc_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .sop_in          (sop_in),
    .ct              (ct),
    .gts_n           (gts_n),
    .pin_in          (pin_in),
    .cfg_bypass      (cfg_bypass),
    .cfg_init_src    (cfg_init_src),
    .cfg_init_preset (cfg_init_preset),
    .cfg_oe_sel      (cfg_oe_sel),
    .cfg_gts_en      (cfg_gts_en),
    .pin_out         (pin_out),
    .pin_oe          (pin_oe),
    .fb_cell         (fb_cell),
    .fb_pin          (fb_pin)
);

// File: tb/cfg_macrocell_test.sv
module cfg_macrocell_test;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic       clk = 1'b0;
    logic       rst;
    logic       sop_in;
    logic [5:0] ct;
    logic       clk0_pin, clk1_pin, clk1_eqn, gts_n, pin_in;
    logic       cfg_t_mode, cfg_bypass, cfg_clk_sel, cfg_clk1_eqn, cfg_clk_fall;
    logic [1:0] cfg_init_src;
    logic       cfg_init_preset;
    logic [2:0] cfg_oe_sel;
    logic       cfg_gts_en;
    logic       pin_out, pin_oe, fb_cell, fb_pin;

    int checks = 0;
    int failures = 0;
    logic mq = 1'b0;
    logic mprev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_macrocell uut (
        .clk(clk), .rst(rst), .sop_in(sop_in), .ct(ct),
        .clk0_pin(clk0_pin), .clk1_pin(clk1_pin), .clk1_eqn(clk1_eqn),
        .gts_n(gts_n), .pin_in(pin_in),
        .cfg_t_mode(cfg_t_mode), .cfg_bypass(cfg_bypass), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk1_eqn(cfg_clk1_eqn), .cfg_clk_fall(cfg_clk_fall),
        .cfg_init_src(cfg_init_src), .cfg_init_preset(cfg_init_preset),
        .cfg_oe_sel(cfg_oe_sel), .cfg_gts_en(cfg_gts_en),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_cell(fb_cell), .fb_pin(fb_pin)
    );

    function automatic logic m_src();
        if (cfg_clk_sel) return cfg_clk1_eqn ? clk1_eqn : clk1_pin;
        return clk0_pin;
    endfunction

    function automatic logic [1:0] m_init(); // {act, val}
        case (cfg_init_src)
            2'd1: return {ct[0], cfg_init_preset};
            2'd2: return {ct[1], cfg_init_preset};
            2'd3: return {ct[0] | ct[1], ~ct[0]};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic m_oe();
        logic b;
        if (cfg_oe_sel < 3'd4)       b = ct[2 + int'(cfg_oe_sel)];
        else if (cfg_oe_sel == 3'd4) b = 1'b1;
        else                         b = 1'b0;
        return b & ~(cfg_gts_en & ~gts_n);
    endfunction

    function automatic logic m_cell();
        logic [1:0] ini;
        ini = m_init();
        if (cfg_bypass) return sop_in;
        return ini[1] ? ini[0] : mq;
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
        end
    endtask

    // one clk cycle: model steps at rising edge, outputs compared at falling edge
    task automatic cycle(input string req);
        logic [1:0] ini;
        logic s, edge_hit;
        @(posedge clk);
        ini = m_init();
        s = m_src();
        edge_hit = cfg_clk_fall ? (mprev & ~s) : (s & ~mprev);
        if (rst) begin
            mq = 1'b0; mprev = 1'b0;
        end else begin
            if (ini[1])        mq = ini[0];
            else if (edge_hit) mq = cfg_t_mode ? (mq ^ sop_in) : sop_in;
            mprev = s;
        end
        @(negedge clk);
        chk(req, "fb_cell", fb_cell, m_cell());
        chk("R11", "pin_out", pin_out, m_cell());
        chk("R9", "pin_oe", pin_oe, m_oe());
        chk("R11", "fb_pin", fb_pin, m_oe() ? m_cell() : pin_in);
    endtask

    task automatic set_defaults();
        sop_in = 0; ct = '0; clk0_pin = 0; clk1_pin = 0; clk1_eqn = 0;
        gts_n = 1; pin_in = 0;
        cfg_t_mode = 0; cfg_bypass = 0; cfg_clk_sel = 0; cfg_clk1_eqn = 0;
        cfg_clk_fall = 0; cfg_init_src = 0; cfg_init_preset = 0;
        cfg_oe_sel = 3'd4; cfg_gts_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        set_defaults();
        rst = 1;
        @(negedge clk);
        repeat (3) cycle("R1");
        rst = 0;
        cycle("R1");
        chk("R1", "reset value", fb_cell, 1'b0);

        // R2: D capture on rising edge of clk0
        sop_in = 1; clk0_pin = 1; cycle("R2");
        chk("R2", "D load", fb_cell, 1'b1);
        sop_in = 0; cycle("R4");
        chk("R4", "hold without edge", fb_cell, 1'b1);
        clk0_pin = 0; cycle("R4");
        chk("R4", "falling ignored in rising mode", fb_cell, 1'b1);

        // R4: falling edge mode
        cfg_clk_fall = 1; cycle("R4");
        clk0_pin = 1; cycle("R4");
        chk("R4", "rising ignored in falling mode", fb_cell, 1'b1);
        clk0_pin = 0; cycle("R4");
        chk("R4", "falling loads", fb_cell, 1'b0);
        cfg_clk_fall = 0;

        // R3: T mode toggle and hold
        cfg_t_mode = 1; sop_in = 1; cycle("R3");
        clk0_pin = 1; cycle("R3");
        chk("R3", "toggle to 1", fb_cell, 1'b1);
        clk0_pin = 0; cycle("R3");
        clk0_pin = 1; cycle("R3");
        chk("R3", "toggle to 0", fb_cell, 1'b0);
        clk0_pin = 0; sop_in = 0; cycle("R3");
        clk0_pin = 1; cycle("R3");
        chk("R3", "hold on 0", fb_cell, 1'b0);
        cfg_t_mode = 0;

        // R5: clock source selection
        clk0_pin = 0; cfg_clk_sel = 1; cycle("R5");
        sop_in = 1; clk0_pin = 1; cycle("R5");
        chk("R5", "clk0 ignored when source 1", fb_cell, 1'b0);
        clk1_pin = 1; cycle("R5");
        chk("R5", "clk1 pin loads", fb_cell, 1'b1);
        cfg_clk1_eqn = 1; sop_in = 0; cycle("R5");
        clk1_pin = 0; cycle("R5");
        clk1_pin = 1; cycle("R5");
        chk("R5", "pin ignored when logic clock", fb_cell, 1'b1);
        clk1_eqn = 1; cycle("R5");
        chk("R5", "logic clock loads", fb_cell, 1'b0);
        cfg_clk_sel = 0; cfg_clk1_eqn = 0; clk0_pin = 0; cycle("R5");

        // R6: init terms
        cfg_init_src = 2'd1; cfg_init_preset = 1; ct[0] = 1; cycle("R6");
        chk("R6", "preset via ct0", fb_cell, 1'b1);
        ct[0] = 0; cycle("R6");
        chk("R6", "preset held", fb_cell, 1'b1);
        cfg_init_src = 2'd2; cfg_init_preset = 0; ct[0] = 1; cycle("R6");
        chk("R6", "ct0 ignored for code 2", fb_cell, 1'b1);
        ct[1] = 1; cycle("R6");
        chk("R6", "reset via ct1", fb_cell, 1'b0);
        ct[1] = 0; ct[0] = 0; cfg_init_src = 2'd0; ct[1:0] = 2'b11; cycle("R6");
        chk("R6", "init disabled", fb_cell, 1'b0);

        // R7: split mode, reset wins
        cfg_init_src = 2'd3; ct[1:0] = 2'b10; cycle("R7");
        chk("R7", "ct1 presets", fb_cell, 1'b1);
        ct[1:0] = 2'b11; cycle("R7");
        chk("R7", "reset wins", fb_cell, 1'b0);
        ct[1:0] = 2'b00; cfg_init_src = 2'd0; cycle("R7");

        // R8: bypass
        cfg_bypass = 1; sop_in = 1; cycle("R8");
        chk("R8", "bypass 1", fb_cell, 1'b1);
        sop_in = 0; cycle("R8");
        chk("R8", "bypass 0", fb_cell, 1'b0);
        cfg_bypass = 0;

        // R9 / R10 / R11: output enable and pad feedback
        for (int code = 0; code < 8; code++) begin
            cfg_oe_sel = 3'(code); ct[5:2] = 4'b0000; cycle("R9");
            if (code < 4) begin
                ct[2 + code] = 1; cycle("R9");
                chk("R9", "enable from ct", pin_oe, 1'b1);
            end
        end
        cfg_oe_sel = 3'd4; cfg_gts_en = 1; gts_n = 0; pin_in = 1; cycle("R10");
        chk("R10", "global tri-state", pin_oe, 1'b0);
        chk("R11", "pad fb from pin_in", fb_pin, 1'b1);
        gts_n = 1; cycle("R10");
        chk("R10", "tri-state released", pin_oe, 1'b1);
        cfg_gts_en = 0; gts_n = 0; cycle("R10");
        chk("R10", "tri-state not enabled", pin_oe, 1'b1);

        // random mix
        for (int i = 0; i < RAND_CYCLES; i++) begin
            if (i % 40 == 0) begin
                cfg_t_mode = 1'($urandom); cfg_bypass = ($urandom % 6) == 0;
                cfg_clk_sel = 1'($urandom); cfg_clk1_eqn = 1'($urandom);
                cfg_clk_fall = 1'($urandom); cfg_init_src = 2'($urandom);
                cfg_init_preset = 1'($urandom); cfg_oe_sel = 3'($urandom);
                cfg_gts_en = 1'($urandom);
            end
            rst = ($urandom % 100) == 0;
            sop_in = 1'($urandom);
            ct[5:2] = 4'($urandom);
            ct[1:0] = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            clk0_pin = (($urandom % 3) == 0) ? ~clk0_pin : clk0_pin;
            clk1_pin = (($urandom % 3) == 0) ? ~clk1_pin : clk1_pin;
            clk1_eqn = (($urandom % 3) == 0) ? ~clk1_eqn : clk1_eqn;
            gts_n = ($urandom % 4) != 0;
            pin_in = 1'($urandom);
            cycle(cfg_t_mode ? "R3" : "R2");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule